// File: doc/BRIEF.md
# 128b/130b Transmit Block Scheduler

This block produces the per-clock transmit control for one lane of a 128b/130b serial link. The lane runs a parallel word path that is narrower than a block. The block sets a data-valid pattern that leaves one idle clock in every gearbox period, so that the PHY has room to insert the 2-bit sync headers. It groups valid clocks into 128-bit blocks and selects the sync type of each block. It also inserts a clock-compensation (SKP) ordered set at a fixed block interval and closes any open data stream with an end-of-data-stream (EDS) token just ahead of that set.

Upstream logic raises `data_req` when it has payload to send. Once a data block has gone out, the stream stays open until the scheduler closes it with EDS. Blocks sent while no stream is open are idle ordered-set blocks. Scrambling, the contents of ordered sets and the data words themselves belong to other logic. The data words are aligned to the `tx_valid` and `blk_start` strobes.

Top module: `tx130_sched`

## Requirements
- R1: While `rst` is high or `link_en` is low, every output is 0 on the next clock, including `sync_sel` = 2'b00. The first output clock after enable is valid and starts a block.
- R2: Counting output clocks from the first enabled one as slot 0, `tx_valid` is low exactly in slots where slot mod GB_PERIOD = GB_PERIOD-1, and high in all other slots.
- R3: A block is WORDS = BLK_W/LANE_W consecutive valid clocks. `blk_start` is high only on the first of them. Block boundaries count valid clocks only.
- R4: `sync_sel` changes only on a `blk_start` clock and holds its value until the next block start. The value is 2'b10 for a data or EDS block and 2'b01 for an ordered-set block.
- R5: Blocks are numbered from 0 in order. Outside the two blocks before each SKP, a block is a data block when `data_req` is high on the clock before its start, or when a stream is already open. Otherwise it is an idle ordered-set block.
- R6: Every block whose number n satisfies n mod SKP_MIN = SKP_MIN-1 is a SKP block. It carries `sync_sel` = 2'b01, and `skp_req` is high on each of its valid clocks. The start-to-start spacing of SKP blocks is therefore SKP_MIN blocks, which lies within [SKP_MIN, SKP_MAX].
- R7: In the block just before a SKP block, `data_req` is ignored. If a stream is open, that block is an EDS data block: `eds_req` is high on its last valid clock, and the stream closes. If no stream is open, the block is an idle ordered-set block and `eds_req` stays low.
- R8: Dropping `link_en` for any number of clocks and then raising it again restarts the gearbox, block and SKP counts from slot 0 and closes the stream.
- R9: An open stream stays open while `data_req` is low. The following blocks are data blocks until an EDS block closes the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Link active; low holds all state cleared |
| data_req | input | 1 | Upstream has payload for the next block |
| tx_valid | output | 1 | Lane word valid this clock |
| blk_start | output | 1 | First valid word of a block |
| sync_sel | output | 2 | Sync header of the current block |
| eds_req | output | 1 | Place the EDS token in this word |
| skp_req | output | 1 | Word belongs to a SKP ordered-set block |

## Verification
The assertions take `link_en` and `data_req` to be synchronous and free of X after reset, and `rst` to be high on the first clock edge. They make no assumption about how long `data_req` is held. The block samples that input only on the clock before a block start, so the stimulus changes it freely one time unit after each edge: held high, held low, a single pulse, and an irregular pattern. The stimulus also drops `link_en` in the middle of a run, which exercises the restart behaviour.

// File: rtl/tx130_pkg.sv
`timescale 1ns/1ps
package tx130_pkg;

  typedef enum logic [1:0] {
    BK_DATA    = 2'd0,
    BK_IDLE_OS = 2'd1,
    BK_EDS     = 2'd2,
    BK_SKP     = 2'd3
  } blk_kind_e;

  localparam logic [1:0] SYNC_DATA = 2'b10;
  localparam logic [1:0] SYNC_OS   = 2'b01;

  function automatic logic [1:0] sync_of(blk_kind_e k);
    return (k == BK_DATA || k == BK_EDS) ? SYNC_DATA : SYNC_OS;
  endfunction

endpackage

// File: rtl/tx130_slot_gen.sv
`timescale 1ns/1ps
module tx130_slot_gen #(
  parameter int GB_PERIOD = 65,
  parameter int WORDS     = 4
) (
  input  logic clk,
  input  logic clr,
  output logic slot_valid,
  output logic word_first,
  output logic word_last
);
  localparam int GB_W = $clog2(GB_PERIOD);
  localparam int WD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [GB_W-1:0] GB_LAST = GB_W'(GB_PERIOD - 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WORDS - 1);

  logic [GB_W-1:0] gb_q;
  logic [WD_W-1:0] wd_q;

  assign slot_valid = (gb_q != GB_LAST);
  assign word_first = (wd_q == '0);
  assign word_last  = (wd_q == WD_LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      gb_q <= '0;
      wd_q <= '0;
    end else begin
      gb_q <= (gb_q == GB_LAST) ? '0 : gb_q + 1'b1;
      if (slot_valid)
        wd_q <= (wd_q == WD_LAST) ? '0 : wd_q + 1'b1;
    end
  end

endmodule

// File: rtl/tx130_blk_seq.sv
`timescale 1ns/1ps
module tx130_blk_seq
  import tx130_pkg::*;
#(
  parameter int SKP_INTERVAL = 370
) (
  input  logic      clk,
  input  logic      clr,
  input  logic      slot_valid,
  input  logic      word_first,
  input  logic      word_last,
  input  logic      data_req,
  output blk_kind_e kind_now
);
  localparam int BC_W = $clog2(SKP_INTERVAL);
  localparam logic [BC_W-1:0] SKP_POS = BC_W'(SKP_INTERVAL - 1);
  localparam logic [BC_W-1:0] PRE_POS = BC_W'(SKP_INTERVAL - 2);

  logic [BC_W-1:0] bcnt_q;
  logic            open_q;
  blk_kind_e       kind_q;
  blk_kind_e       kind_sel;
  logic            blk_begin;
  logic            blk_end;

  assign blk_begin = slot_valid && word_first;
  assign blk_end   = slot_valid && word_last;

  always_comb begin
    if (bcnt_q == SKP_POS)
      kind_sel = BK_SKP;
    else if (bcnt_q == PRE_POS)
      kind_sel = open_q ? BK_EDS : BK_IDLE_OS;
    else
      kind_sel = (data_req || open_q) ? BK_DATA : BK_IDLE_OS;
  end

  assign kind_now = blk_begin ? kind_sel : kind_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      bcnt_q <= '0;
      open_q <= 1'b0;
      kind_q <= BK_IDLE_OS;
    end else begin
      if (blk_begin)
        kind_q <= kind_sel;
      if (blk_begin && kind_sel == BK_DATA)
        open_q <= 1'b1;
      else if (blk_end && kind_now == BK_EDS)
        open_q <= 1'b0;
      if (blk_end)
        bcnt_q <= (bcnt_q == SKP_POS) ? '0 : bcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tx130_sched.sv
`timescale 1ns/1ps
module tx130_sched
  import tx130_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int BLK_W     = 128,
  parameter int GB_PERIOD = 65,
  parameter int SKP_MIN   = 370,
  parameter int SKP_MAX   = 375
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_en,
  input  logic       data_req,
  output logic       tx_valid,
  output logic       blk_start,
  output logic [1:0] sync_sel,
  output logic       eds_req,
  output logic       skp_req
);
  localparam int WORDS = BLK_W / LANE_W;
  localparam int RUN_W = $clog2(GB_PERIOD) + 1;

  if (SKP_MIN < 3 || SKP_MIN > SKP_MAX || WORDS < 1 || GB_PERIOD < 2) begin : g_bad_cfg
    $error("tx130_sched: parameter set out of range");
  end

  logic      clr;
  logic      slot_valid;
  logic      word_first;
  logic      word_last;
  blk_kind_e kind_now;

  assign clr = rst || !link_en;

  tx130_slot_gen #(
    .GB_PERIOD (GB_PERIOD),
    .WORDS     (WORDS)
  ) u_slot (
    .clk        (clk),
    .clr        (clr),
    .slot_valid (slot_valid),
    .word_first (word_first),
    .word_last  (word_last)
  );

  tx130_blk_seq #(
    .SKP_INTERVAL (SKP_MIN)
  ) u_seq (
    .clk        (clk),
    .clr        (clr),
    .slot_valid (slot_valid),
    .word_first (word_first),
    .word_last  (word_last),
    .data_req   (data_req),
    .kind_now   (kind_now)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      tx_valid  <= 1'b0;
      blk_start <= 1'b0;
      sync_sel  <= 2'b00;
      eds_req   <= 1'b0;
      skp_req   <= 1'b0;
    end else begin
      tx_valid  <= slot_valid;
      blk_start <= slot_valid && word_first;
      if (slot_valid && word_first)
        sync_sel <= sync_of(kind_now);
      eds_req   <= slot_valid && word_last && (kind_now == BK_EDS);
      skp_req   <= slot_valid && (kind_now == BK_SKP);
    end
  end

  // Checker state: length of the current run of valid output clocks.
  logic [RUN_W-1:0] chk_run;
  always_ff @(posedge clk) begin
    if (rst || !tx_valid)
      chk_run <= '0;
    else if (chk_run < RUN_W'(GB_PERIOD))
      chk_run <= chk_run + 1'b1;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !link_en |=> (!tx_valid && !blk_start && !eds_req && !skp_req && sync_sel == 2'b00)); // R1

  AST_VALID_RUN: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (chk_run < RUN_W'(GB_PERIOD - 1))); // R2

  AST_START_VALID: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> tx_valid); // R3

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !blk_start) |-> $stable(sync_sel)); // R4

  AST_SKP_OS_SYNC: assert property (@(posedge clk) disable iff (rst)
    skp_req |-> (sync_sel == SYNC_OS && tx_valid)); // R6

  AST_EDS_DATA_SYNC: assert property (@(posedge clk) disable iff (rst)
    eds_req |-> (sync_sel == SYNC_DATA && !skp_req && !blk_start)); // R7

endmodule

// File: tb/tx130_sched_bench.sv
`timescale 1ns/1ps
module tx130_sched_bench;
  localparam int LANE_W = 32;
  localparam int BLK_W  = 128;
  localparam int GBP    = 65;
  localparam int SKPI   = 10;
  localparam int WORDS  = BLK_W / LANE_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       link_en = 1'b0;
  logic       data_req = 1'b0;
  logic       tx_valid, blk_start, eds_req, skp_req;
  logic [1:0] sync_sel;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1";

  // reference state
  int         s = 0;
  bit         e_open = 0;
  int         e_kind = 1;
  logic [1:0] e_sync = 2'b00;
  int         skp_seen = 0;
  int         eds_seen = 0;

  always #2 clk = ~clk;

  tx130_sched #(
    .LANE_W(LANE_W), .BLK_W(BLK_W), .GB_PERIOD(GBP), .SKP_MIN(SKPI), .SKP_MAX(12)
  ) u_tx130_sched (
    .clk(clk), .rst(rst), .link_en(link_en), .data_req(data_req),
    .tx_valid(tx_valid), .blk_start(blk_start), .sync_sel(sync_sel),
    .eds_req(eds_req), .skp_req(skp_req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
    end
  endtask

  task automatic step();
    bit ev, es, ee, ek;
    @(posedge clk);
    #1;
    if (rst || !link_en) begin
      ev = 0; es = 0; ee = 0; ek = 0;
      e_sync = 2'b00; s = 0; e_open = 0; e_kind = 1;
    end else begin
      int v, w, b, pos;
      ev  = (s % GBP) != GBP - 1;
      v   = s - s / GBP;
      w   = v % WORDS;
      b   = v / WORDS;
      pos = b % SKPI;
      if (ev && w == 0) begin
        if (pos == SKPI - 1)      e_kind = 3;
        else if (pos == SKPI - 2) e_kind = e_open ? 2 : 1;
        else                      e_kind = (data_req || e_open) ? 0 : 1;
        e_sync = (e_kind == 0 || e_kind == 2) ? 2'b10 : 2'b01;
        if (e_kind == 0) e_open = 1;
      end
      es = ev && w == 0;
      ee = ev && w == WORDS - 1 && e_kind == 2;
      ek = ev && e_kind == 3;
      if (ee) e_open = 0;
      s++;
    end
    chk("R2 tx_valid", tx_valid, ev);
    chk("R3 blk_start", blk_start, es);
    chk("R4 sync_sel", sync_sel, e_sync);
    chk("R7 eds_req", eds_req, ee);
    chk("R6 skp_req", skp_req, ek);
    if (skp_req && blk_start) skp_seen++;
    if (eds_req) eds_seen++;
  endtask

  initial begin
    // R1: reset and disabled state
    phase = "R1 reset";
    rst = 1; link_en = 0;
    repeat (4) step();
    rst = 0;
    repeat (4) step();

    // R5/R6/R7: continuous upstream data
    phase = "R5 req high";
    link_en = 1; data_req = 1;
    repeat (2000) step();
    chk("R6 skp count high", skp_seen > 0, 1);
    chk("R7 eds count high", eds_seen > 0, 1);

    // R7: stream never opened, so no EDS
    phase = "R7 closed";
    rst = 1; step(); rst = 0; data_req = 0;
    eds_seen = 0;
    repeat (1500) step();
    chk("R7 no eds closed", eds_seen, 0);

    // R9: single pulse opens a stream that persists
    phase = "R9 pulse";
    rst = 1; step(); rst = 0;
    data_req = 1; step(); data_req = 0;
    repeat (1500) step();

    // R5: irregular request pattern
    phase = "R5 pattern";
    for (int i = 0; i < 3000; i++) begin
      data_req = ((i * 7 + i / 13) % 11) < 3;
      step();
    end

    // R8: drop link_en mid-run, then resume
    phase = "R8 restart";
    data_req = 1;
    link_en = 0; repeat (3) step();
    link_en = 1; repeat (700) step();
    link_en = 0; step();
    data_req = 0;
    link_en = 1; repeat (1200) step();

    // R1: reset mid-run
    phase = "R1 midrun";
    rst = 1; repeat (2) step();
    rst = 0; repeat (10) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule